// File: doc/BRIEF.md
# Two-Digit BCD to Binary Converter

This block turns a packed decimal value of two 4-bit digits into a 7-bit unsigned binary number. The tens digit sits in the upper nibble of the input. The block holds two independent implementations side by side, and both read the same decimal input.

The first implementation is purely combinational. It evaluates tens times ten plus ones as a sum of shifts, so its result follows the input in the same cycle. The second is a small control machine with a datapath. A start pulse captures the input. The datapath then runs a fixed number of right shifts, with a "minus three on any nibble of eight or more" correction after each shift. It reports completion with a one-cycle done pulse and holds its result until the next run ends.

Both paths flag any digit above nine. For such an input the binary value is undefined. The digit count is a parameter, and the binary width and the iteration count are derived from it.

Top module: `bcd2bin_conv`

## Requirements
- R1: For a valid input, comb_bin_o equals 10 × bcd_i[7:4] + bcd_i[3:0] in the same cycle.
- R2: comb_err_o is high exactly when bcd_i[7:4] or bcd_i[3:0] is greater than 9.
- R3: A start_i sampled high while busy_o is low raises busy_o after that edge. busy_o stays high for 8 cycles and then falls.
- R4: Count the rising edge that samples start_i as edge 0. done_o is high for exactly the one cycle between edges 7 and 8.
- R5: While done_o is high after a valid capture, seq_bin_o equals 10 × tens + ones of the input captured at the start edge.
- R6: seq_err_o updates together with done_o. It is high exactly when the captured input had a digit above 9. Changes on bcd_i after the start edge have no effect on seq_bin_o or seq_err_o.
- R7: seq_bin_o and seq_err_o change only at the edge that raises done_o. A start_i while busy_o is high is ignored: the run keeps its timing and its result.
- R8: While rst_ni is low, busy_o, done_o and seq_err_o are 0 and seq_bin_o is 0.
- R9: For all 100 valid inputs, seq_bin_o at done equals comb_bin_o for the same input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcd_i | input | 8 | Packed BCD value, tens digit in bits 7:4 |
| start_i | input | 1 | Begin an iterative conversion (honoured when idle) |
| comb_bin_o | output | 7 | Combinational binary result |
| comb_err_o | output | 1 | Combinational invalid-digit flag |
| busy_o | output | 1 | Iterative path is running |
| done_o | output | 1 | One-cycle completion pulse |
| seq_bin_o | output | 7 | Iterative binary result, held |
| seq_err_o | output | 1 | Invalid-digit flag of the captured input, held |

## Verification
The combinational results are due in the same cycle as the input. The bench changes bcd_i at a falling edge and compares one time step later. The iterative result is due seven edges after the start edge. The bench therefore counts edges from the one that samples start_i and checks done_o and the result at the falling edge of the cycle after the seventh. It then checks again after the eighth edge, where done_o must be low and the result unchanged. bcd_i is scrambled right after capture, and extra start pulses are injected mid-run, so any dependence on live input or on repeated starts shows up in the values compared at done.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } conv_state_e;

  function automatic logic nib_bad(input logic [NIB_W-1:0] nib);
    return nib > 4'd9;
  endfunction

  // correction applied after each right shift
  function automatic logic [NIB_W-1:0] nib_fix(input logic [NIB_W-1:0] nib);
    return (nib >= 4'd8) ? nib - 4'd3 : nib;
  endfunction
endpackage

// File: rtl/bcd2bin_comb.sv
module bcd2bin_comb
  import bcd2bin_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned BCD_W = DIGITS * NIB_W,
  localparam int unsigned BIN_W = $clog2(10 ** DIGITS)
) (
  input  logic [BCD_W-1:0] bcd_i,
  output logic [BIN_W-1:0] bin_o,
  output logic             err_o
);
  logic [BIN_W-1:0] acc [DIGITS+1];
  logic [DIGITS-1:0] bad;

  assign acc[0] = '0;

  // Horner: acc = acc*10 + digit, most significant digit first
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    localparam int unsigned POS = (DIGITS - 1 - g) * NIB_W;
    logic [NIB_W-1:0] dig;
    assign dig        = bcd_i[POS +: NIB_W];
    assign acc[g+1]   = (acc[g] << 3) + (acc[g] << 1) + BIN_W'(dig);
    assign bad[g]     = nib_bad(dig);
  end

  assign bin_o = acc[DIGITS];
  assign err_o = |bad;
endmodule

// File: rtl/bcd2bin_ctrl.sv
module bcd2bin_ctrl
  import bcd2bin_pkg::*;
#(
  parameter int unsigned ITER = 7,
  localparam int unsigned CNT_W = $clog2(ITER + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  conv_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign shift_o = (state_q == ST_RUN);
  assign last_o  = shift_o && (cnt_q == CNT_W'(ITER - 1));
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (last_o) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bcd2bin_dp.sv
module bcd2bin_dp
  import bcd2bin_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned BCD_W = DIGITS * NIB_W,
  localparam int unsigned BIN_W = $clog2(10 ** DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             last_i,
  input  logic [BCD_W-1:0] bcd_i,
  output logic [BIN_W-1:0] res_o,
  output logic             err_o
);
  logic [BCD_W-1:0] dec_q, dec_sh, dec_fix;
  logic [BIN_W-1:0] bin_q, bin_d;
  logic [BIN_W-1:0] res_q;
  logic             err_cap_q, err_q;
  logic [DIGITS-1:0] in_bad;

  assign dec_sh = dec_q >> 1;
  assign bin_d  = {dec_q[0], bin_q[BIN_W-1:1]};

  for (genvar g = 0; g < DIGITS; g++) begin : g_nib
    assign dec_fix[g*NIB_W +: NIB_W] = nib_fix(dec_sh[g*NIB_W +: NIB_W]);
    assign in_bad[g]                 = nib_bad(bcd_i[g*NIB_W +: NIB_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q     <= '0;
      bin_q     <= '0;
      err_cap_q <= 1'b0;
    end else if (load_i) begin
      dec_q     <= bcd_i;
      bin_q     <= '0;
      err_cap_q <= |in_bad;
    end else if (shift_i) begin
      dec_q     <= dec_fix;
      bin_q     <= bin_d;
    end
  end

  // result registers move only on the final shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else if (last_i) begin
      res_q <= bin_d;
      err_q <= err_cap_q;
    end
  end

  assign res_o = res_q;
  assign err_o = err_q;
endmodule

// File: rtl/bcd2bin_conv.sv
module bcd2bin_conv
  import bcd2bin_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned BCD_W = DIGITS * NIB_W,
  localparam int unsigned BIN_W = $clog2(10 ** DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BCD_W-1:0] bcd_i,
  input  logic             start_i,
  output logic [BIN_W-1:0] comb_bin_o,
  output logic             comb_err_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [BIN_W-1:0] seq_bin_o,
  output logic             seq_err_o
);
  logic load, shift, last;

  bcd2bin_comb #(.DIGITS(DIGITS)) u_comb (
    .bcd_i (bcd_i),
    .bin_o (comb_bin_o),
    .err_o (comb_err_o)
  );

  bcd2bin_ctrl #(.ITER(BIN_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .shift_o (shift),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  bcd2bin_dp #(.DIGITS(DIGITS)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .last_i  (last),
    .bcd_i   (bcd_i),
    .res_o   (seq_bin_o),
    .err_o   (seq_err_o)
  );
endmodule

// File: rtl/bcd2bin_chk.sv
module bcd2bin_chk
  import bcd2bin_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned BCD_W = DIGITS * NIB_W,
  localparam int unsigned BIN_W = $clog2(10 ** DIGITS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [BCD_W-1:0] bcd_i,
  input logic             start_i,
  input logic [BIN_W-1:0] comb_bin_o,
  input logic             comb_err_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [BIN_W-1:0] seq_bin_o,
  input logic             seq_err_o
);
  localparam int unsigned MAXV = 10 ** DIGITS - 1;
  logic [7:0] run_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_cnt_q <= '0;
    else if (start_i && !busy_o) run_cnt_q <= 8'd1;
    else if (busy_o)             run_cnt_q <= run_cnt_q + 8'd1;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o) else $error("start not taken"); // R3
  AST_DONE_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt_q == 8'(BIN_W + 1))) else $error("done late/early"); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)) else $error("done not a pulse"); // R4
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(seq_bin_o) && $stable(seq_err_o))) else $error("result moved"); // R7
  AST_COMB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comb_err_o |-> (comb_bin_o <= BIN_W'(MAXV))) else $error("comb out of range"); // R1
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o) else $error("done while idle"); // R3
endmodule

bind bcd2bin_conv bcd2bin_chk #(.DIGITS(DIGITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bcd_i      (bcd_i),
  .start_i    (start_i),
  .comb_bin_o (comb_bin_o),
  .comb_err_o (comb_err_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .seq_bin_o  (seq_bin_o),
  .seq_err_o  (seq_err_o)
);

// File: tb/bcd2bin_conv_test.sv
module bcd2bin_conv_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bcd_i = '0;
  logic       start_i = 1'b0;
  logic [6:0] comb_bin_o, seq_bin_o;
  logic       comb_err_o, busy_o, done_o, seq_err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd2bin_conv uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .bcd_i      (bcd_i),
    .start_i    (start_i),
    .comb_bin_o (comb_bin_o),
    .comb_err_o (comb_err_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .seq_bin_o  (seq_bin_o),
    .seq_err_o  (seq_err_o)
  );

  function automatic logic [6:0] exp_val(input logic [7:0] b);
    return 7'((int'(b[7:4]) * 10 + int'(b[3:0])) % 128);
  endfunction

  function automatic logic exp_err(input logic [7:0] b);
    return (b[7:4] > 4'd9) || (b[3:0] > 4'd9);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic comb_check(input logic [7:0] b);
    @(negedge clk);
    bcd_i = b;
    #1;
    chk("R2 comb_err", int'(comb_err_o), int'(exp_err(b)));
    if (!exp_err(b)) chk("R1 comb_bin", int'(comb_bin_o), int'(exp_val(b)));
  endtask

  // runs one iterative conversion; restart injects a start during the run
  task automatic seq_run(input logic [7:0] b, input bit restart, input bit vs_comb);
    logic [6:0] ref_comb;
    @(negedge clk);
    bcd_i = b;
    #1 ref_comb = comb_bin_o;
    start_i = 1'b1;
    @(posedge clk);                        // edge 0
    @(negedge clk);
    start_i = 1'b0;
    bcd_i = 8'($urandom);                  // R6: live input must not matter
    chk("R3 busy after start", int'(busy_o), 1);
    chk("R4 no early done", int'(done_o), 0);
    for (int k = 1; k <= 7; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (restart && k == 3) start_i = 1'b1;
      if (restart && k == 4) start_i = 1'b0;
      if (k < 7) begin
        chk("R3 busy mid run", int'(busy_o), 1);
        chk("R4 done low mid run", int'(done_o), 0);
      end
    end
    chk("R4 done pulse", int'(done_o), 1);
    chk("R6 seq_err", int'(seq_err_o), int'(exp_err(b)));
    if (!exp_err(b)) begin
      chk("R5 seq_bin", int'(seq_bin_o), int'(exp_val(b)));
      if (vs_comb) chk("R9 seq vs comb", int'(seq_bin_o), int'(ref_comb));
    end
    @(posedge clk);                        // edge 8
    @(negedge clk);
    chk("R4 done one cycle", int'(done_o), 0);
    chk("R3 busy falls", int'(busy_o), 0);
    if (!exp_err(b)) chk("R7 result held", int'(seq_bin_o), int'(exp_val(b)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2);
    #1;
    chk("R8 reset busy", int'(busy_o), 0);
    chk("R8 reset done", int'(done_o), 0);
    chk("R8 reset seq_bin", int'(seq_bin_o), 0);
    chk("R8 reset seq_err", int'(seq_err_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R2: every input code
    for (int v = 0; v < 256; v++) comb_check(8'(v));

    // directed corners
    seq_run(8'h00, 1'b0, 1'b1);
    seq_run(8'h99, 1'b0, 1'b1);
    seq_run(8'h90, 1'b0, 1'b1);
    seq_run(8'h09, 1'b0, 1'b1);
    seq_run(8'hA5, 1'b0, 1'b0);
    seq_run(8'h3F, 1'b0, 1'b0);
    seq_run(8'h42, 1'b1, 1'b1);            // R7 start while busy ignored

    // R7: result stays after done while input moves
    repeat (3) begin
      @(negedge clk);
      bcd_i = 8'($urandom);
      chk("R7 hold after done", int'(seq_bin_o), int'(exp_val(8'h42)));
    end

    // R9: all valid inputs
    for (int t = 0; t < 10; t++)
      for (int o = 0; o < 10; o++)
        seq_run({4'(t), 4'(o)}, 1'b0, 1'b1);

    // random mix including invalid digits
    for (int n = 0; n < 60; n++)
      seq_run(8'($urandom), ($urandom % 4) == 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule